// File: doc/BRIEF.md
# Open-Collector I/O Port Decoder

This block sits between a CPU's I/O cycles and four peripherals: a video gate array, a CRT controller, a parallel I/O chip and an optional floppy controller. It decodes the 16-bit port address into selects and register indices. The decode is partial, so one address can select several devices at once.

On an input cycle every selected readable device drives the bus at the same time. The byte returned is the bitwise AND of their read data, as on an open-collector bus, and it is 0xFF when no readable device answers. The two write-only devices do not look at the cycle direction. During an input cycle the CRT controller's select and write functions still fire, and the gate array still takes a write. Both sample the merged bus value.

Selects and strobes are combinational from the address and the cycle strobes. The merged read byte is captured on each clock edge at which the read strobe is high, so the CPU samples a stable value.

Top module: `io_port_decoder`

## Requirements
- R1: `ga_wr` is high during any input or output cycle whose address bits 15:14 are binary 01, and low otherwise.
- R2: On an output cycle with address bit 14 low, address bits 9:8 equal to 0 raise `crtc_sel_strb` and equal to 1 raise `crtc_data_strb`; values 2 and 3 raise neither strobe nor `crtc_rd`. `crtc_fn` always shows address bits 9:8.
- R3: With address bit 11 low, `pio_rd` or `pio_wr` follows the cycle type. `pio_idx` always shows address bits 9:8.
- R4: `fdc_rd` or `fdc_wr` is raised only when `fdc_fitted` is high and (address AND 0x0580) equals 0x0100. `fdc_idx` always shows address bit 0.
- R5: On an input cycle, `bus_out` is 0xFF ANDed with the read data of each device whose read strobe is active.
- R6: On an input cycle with address bit 14 low and bits 9:8 equal to 0 or 1, the matching CRT controller write strobe is raised and `bus_out` carries the merged value.
- R7: On an input cycle whose address selects the gate array, `ga_wr` is raised and `bus_out` carries the merged value.
- R8: `cpu_rdata` is 0xFF after reset. It takes the merged value at each clock edge where `io_rd` is high, and it holds its value at all other edges.
- R9: On an output cycle, `bus_out` equals `cpu_wdata`.
- R10: `crtc_rd` is high only on an input cycle with address bit 14 low and bits 9:8 equal to 2 (status) or 3 (register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 16 | I/O port address |
| cpu_wdata | input | DW | CPU output data |
| io_rd | input | 1 | Input-cycle strobe |
| io_wr | input | 1 | Output-cycle strobe |
| fdc_fitted | input | 1 | Floppy controller present |
| cpu_rdata | output | DW | Registered merged read byte |
| bus_out | output | DW | Data presented to all peripherals |
| ga_wr | output | 1 | Gate array write |
| crtc_fn | output | 2 | CRT controller function (address bits 9:8) |
| crtc_sel_strb | output | 1 | CRT controller register-select write |
| crtc_data_strb | output | 1 | CRT controller register write |
| crtc_rd | output | 1 | CRT controller status/register read |
| crtc_rdata | input | DW | CRT controller read data |
| pio_rd | output | 1 | Parallel I/O read |
| pio_wr | output | 1 | Parallel I/O write |
| pio_idx | output | 2 | Parallel I/O register index |
| pio_rdata | input | DW | Parallel I/O read data |
| fdc_rd | output | 1 | Floppy controller read |
| fdc_wr | output | 1 | Floppy controller write |
| fdc_idx | output | 1 | Floppy controller register index |
| fdc_rdata | input | DW | Floppy controller read data |

## Verification
The bench builds the block with its default 8-bit data width. At that width, hand-picked byte patterns can show each device's bits being cleared in the merge. The address set includes overlapping decodes: gate array with parallel I/O, CRT controller with parallel I/O, and all three of CRT controller, parallel I/O and floppy controller. These show the AND merge, the writes that happen during input cycles, and the floppy controller being suppressed when `fdc_fitted` is low.

// File: rtl/io_port_decoder.sv
module io_port_decoder #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          io_rd,
  input  logic          io_wr,
  input  logic          fdc_fitted,
  output logic [DW-1:0] cpu_rdata,
  output logic [DW-1:0] bus_out,
  output logic          ga_wr,
  output logic [1:0]    crtc_fn,
  output logic          crtc_sel_strb,
  output logic          crtc_data_strb,
  output logic          crtc_rd,
  input  logic [DW-1:0] crtc_rdata,
  output logic          pio_rd,
  output logic          pio_wr,
  output logic [1:0]    pio_idx,
  input  logic [DW-1:0] pio_rdata,
  output logic          fdc_rd,
  output logic          fdc_wr,
  output logic          fdc_idx,
  input  logic [DW-1:0] fdc_rdata
);
  localparam logic [15:0] FDC_MASK  = 16'h0580;
  localparam logic [15:0] FDC_MATCH = 16'h0100;
  localparam logic [DW-1:0] IDLE_BUS = '1;

  logic          any_cyc, ga_hit, crtc_hit, pio_hit, fdc_hit;
  logic [DW-1:0] merged;

  assign any_cyc  = io_rd | io_wr;
  assign ga_hit   = cpu_addr[15:14] == 2'b01;
  assign crtc_hit = ~cpu_addr[14];
  assign pio_hit  = ~cpu_addr[11];
  assign fdc_hit  = fdc_fitted && ((cpu_addr & FDC_MASK) == FDC_MATCH);

  assign crtc_fn        = cpu_addr[9:8];
  assign pio_idx        = cpu_addr[9:8];
  assign fdc_idx        = cpu_addr[0];

  assign ga_wr          = any_cyc & ga_hit;
  assign crtc_sel_strb  = any_cyc & crtc_hit & (crtc_fn == 2'd0);
  assign crtc_data_strb = any_cyc & crtc_hit & (crtc_fn == 2'd1);
  assign crtc_rd        = io_rd & crtc_hit & crtc_fn[1];
  assign pio_rd         = io_rd & pio_hit;
  assign pio_wr         = io_wr & pio_hit;
  assign fdc_rd         = io_rd & fdc_hit;
  assign fdc_wr         = io_wr & fdc_hit;

  assign merged = IDLE_BUS
                & (pio_rd  ? pio_rdata  : IDLE_BUS)
                & (fdc_rd  ? fdc_rdata  : IDLE_BUS)
                & (crtc_rd ? crtc_rdata : IDLE_BUS);

  assign bus_out = io_rd ? merged : cpu_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cpu_rdata <= IDLE_BUS;
    else if (io_rd) cpu_rdata <= merged;
  end

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(cpu_rdata));

  // R5
  pio_bits_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && pio_rd) |=> ((cpu_rdata & ~$past(pio_rdata)) == '0));

  // R10
  crtc_rd_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && !io_rd |-> !crtc_rd);

  // R4
  fdc_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fdc_rd || fdc_wr) |-> fdc_fitted);

  // R1
  ga_crtc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ga_wr |-> !(crtc_sel_strb || crtc_data_strb || crtc_rd));

  // R6
  crtc_onefn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({crtc_sel_strb, crtc_data_strb, crtc_rd}));
endmodule

// File: tb/test_io_port_decoder.sv
module test_io_port_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, crtc_rdata = '1, pio_rdata = '1, fdc_rdata = '1;
  logic io_rd = 1'b0, io_wr = 1'b0, fdc_fitted = 1'b0;
  logic [7:0] cpu_rdata, bus_out;
  logic ga_wr, crtc_sel_strb, crtc_data_strb, crtc_rd, pio_rd, pio_wr, fdc_rd, fdc_wr, fdc_idx;
  logic [1:0] crtc_fn, pio_idx;

  always #4 clk = ~clk;

  io_port_decoder #(.DW(8)) i_io_port_decoder (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .fdc_fitted(fdc_fitted),
    .cpu_rdata(cpu_rdata), .bus_out(bus_out), .ga_wr(ga_wr), .crtc_fn(crtc_fn),
    .crtc_sel_strb(crtc_sel_strb), .crtc_data_strb(crtc_data_strb), .crtc_rd(crtc_rd),
    .crtc_rdata(crtc_rdata), .pio_rd(pio_rd), .pio_wr(pio_wr), .pio_idx(pio_idx),
    .pio_rdata(pio_rdata), .fdc_rd(fdc_rd), .fdc_wr(fdc_wr), .fdc_idx(fdc_idx),
    .fdc_rdata(fdc_rdata));

  typedef struct {
    logic [12:0] ctl;
    logic [7:0]  bus;
    logic [7:0]  rdata;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_rd = 8'hFF;
  bit driver_done = 0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(logic [15:0] a, logic [7:0] wd, logic rd, logic wr, logic fit,
                     logic [7:0] pr, logic [7:0] fr, logic [7:0] cr, string tag);
    exp_t e;
    logic gah, crh, pih, fdh, e_ga, e_cs, e_cd, e_cr, e_pr, e_pw, e_fr, e_fw;
    logic [7:0] m;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = wd; io_rd = rd; io_wr = wr; fdc_fitted = fit;
    pio_rdata = pr; fdc_rdata = fr; crtc_rdata = cr;
    gah = (a[15] == 1'b0) && (a[14] == 1'b1);
    crh = !a[14];
    pih = !a[11];
    fdh = fit && a[10] == 1'b0 && a[8] == 1'b1 && a[7] == 1'b0;
    e_ga = (rd || wr) && gah;
    e_cs = (rd || wr) && crh && a[9:8] == 2'd0;
    e_cd = (rd || wr) && crh && a[9:8] == 2'd1;
    e_cr = rd && crh && a[9:8] >= 2'd2;
    e_pr = rd && pih; e_pw = wr && pih;
    e_fr = rd && fdh; e_fw = wr && fdh;
    m = 8'hFF;
    if (e_pr) m = m & pr;
    if (e_fr) m = m & fr;
    if (e_cr) m = m & cr;
    if (rd) exp_rd = m;
    e.ctl = {e_ga, e_cs, e_cd, e_cr, e_pr, e_pw, e_fr, e_fw, a[9:8], a[9:8], a[0]};
    e.bus = rd ? m : wd;
    e.rdata = exp_rd;
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t it;
    forever begin
      @(negedge clk); #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        check(it.tag, "ctl", {19'd0, ga_wr, crtc_sel_strb, crtc_data_strb, crtc_rd,
              pio_rd, pio_wr, fdc_rd, fdc_wr, crtc_fn, pio_idx, fdc_idx}, {19'd0, it.ctl});
        check(it.tag, "bus_out", {24'd0, bus_out}, {24'd0, it.bus});
        @(posedge clk); #2;
        check(it.tag, "cpu_rdata", {24'd0, cpu_rdata}, {24'd0, it.rdata});
      end
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R8", "reset cpu_rdata", {24'd0, cpu_rdata}, 32'hFF);
    cyc(16'h7F00, 8'h8D, 0, 1, 0, 8'hFF, 8'hFF, 8'hFF, "R1");
    cyc(16'hBC00, 8'h0C, 0, 1, 0, 8'hFF, 8'hFF, 8'hFF, "R2");
    cyc(16'hBD00, 8'h30, 0, 1, 0, 8'hFF, 8'hFF, 8'hFF, "R2");
    cyc(16'hBE00, 8'h11, 0, 1, 0, 8'hFF, 8'hFF, 8'h00, "R2");
    cyc(16'hBF00, 8'h22, 0, 1, 0, 8'hFF, 8'hFF, 8'h00, "R10");
    cyc(16'hF600, 8'h55, 0, 1, 0, 8'hFF, 8'hFF, 8'hFF, "R3");
    cyc(16'hF400, 8'h00, 1, 0, 0, 8'h3C, 8'hFF, 8'hFF, "R3");
    cyc(16'hFB7F, 8'h00, 1, 0, 1, 8'h00, 8'h81, 8'h00, "R4");
    cyc(16'hFB7F, 8'h00, 1, 0, 0, 8'h00, 8'h81, 8'h00, "R4");
    cyc(16'hBF00, 8'h00, 1, 0, 0, 8'hFF, 8'hFF, 8'h5A, "R10");
    cyc(16'hBE00, 8'h00, 1, 0, 0, 8'hFF, 8'hFF, 8'h0F, "R10");
    cyc(16'hB600, 8'h00, 1, 0, 0, 8'hF0, 8'hFF, 8'h3C, "R5");
    cyc(16'hB400, 8'h00, 1, 0, 0, 8'hA5, 8'hFF, 8'h00, "R6");
    cyc(16'hBD00, 8'h00, 1, 0, 0, 8'h00, 8'hFF, 8'h00, "R6");
    cyc(16'h4000, 8'h00, 1, 0, 0, 8'h96, 8'hFF, 8'h00, "R7");
    cyc(16'h7F00, 8'h00, 1, 0, 0, 8'h00, 8'h00, 8'h00, "R7");
    cyc(16'hF400, 8'h00, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R8");
    cyc(16'h4000, 8'hC3, 0, 1, 0, 8'h00, 8'h00, 8'h00, "R9");
    cyc(16'h0100, 8'h7E, 0, 1, 1, 8'h00, 8'h00, 8'h00, "R9");
    cyc(16'h0101, 8'h00, 1, 0, 1, 8'hCF, 8'h7C, 8'hFF, "R5");
    cyc(16'h0000, 8'h00, 0, 0, 1, 8'h00, 8'h00, 8'h00, "R8");
    @(negedge clk);
    io_rd = 1'b0; io_wr = 1'b0;
    wait (q.size() == 0);
    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule